// File: doc/BRIEF.md
# Four-Channel PWM Generator with Two-Stage Output Inversion

This block drives four independent pulse-width modulated signals. Each channel has its own count range and its own active width, both held in registers. Each channel also selects one of two counting styles. Edge-aligned counting ramps up and wraps. Center-aligned counting ramps up and then back down, which gives a symmetric pulse at half the repetition rate. A per-channel select slows the channel's counter to one step every 64 clocks instead of one step every clock. The width and range are set together, so the resolution can be anything from a few bits up to the full counter width.

A channel's raw waveform goes through two XOR stages before it reaches the pin. The first is a polarity bit and the second is a port-level invert bit, so setting both leaves the signal in its true sense. A separate per-channel drive-enable output tells the pad whether to drive. An external pull-up combined with a disabled driver gives open-drain style, wired-AND outputs.

All configuration arrives through a single-cycle write strobe with an address and a data word. New range, width and counting-style values are buffered and take effect only when the channel begins its next period, so a write never shortens or splits a pulse.

Top module: `pwm_quad`

## Requirements
- R1: The four channels run independently. A write to one channel's range, width or per-channel bits does not alter another channel's waveform.
- R2: With the style bit at 0 (edge-aligned), a channel with range P and width D repeats every P+1 counter steps. Its raw output is active during steps 0 to D-1 of each period.
- R3: With the style bit at 1 (center-aligned), the counter runs 0 up to P and then P down to 0, visiting each end twice. The period is 2(P+1) steps and the raw output is active for 2·min(D, P+1) steps in one contiguous pulse.
- R4: Prescale bit 0 advances the channel counter on every clock. Prescale bit 1 advances it once every 64 clocks.
- R5: A width of 0 keeps the raw output inactive at all times. A width greater than P keeps it active at all times.
- R6: Writes to range, width or style are buffered and applied only at the start of the channel's next period. A period already under way finishes with its old values.
- R7: The polarity bit of a channel XORs the raw output. 0 passes it through and 1 inverts it.
- R8: The port-invert bit XORs the result again, so setting both the polarity and port-invert bits of a channel gives the uninverted raw signal on `pwm_pin`.
- R9: `pwm_oe[n]` follows the drive-enable bit of channel n, one clock after that bit is written.
- R10: After reset, every register is zero, `pwm_pin` is all zero and `pwm_oe` is all zero.
- R11: Register map, where bit n of each bit register belongs to channel n and only bits 3..0 are stored. Address 0 holds polarity, 1 holds port-invert, 2 holds drive-enable, 3 holds style (1 = center-aligned) and 4 holds prescale (1 = divide by 64). Address 8+n holds the range of channel n and 12+n holds its width. Writes to addresses 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 16 | Write data |
| pwm_pin | output | 4 | Per-channel PWM signal after both inversion stages |
| pwm_oe | output | 4 | Per-channel pad drive enable |

## Verification
A fault in a channel's counter or its buffered limits shows up within one period as a wrong number of active cycles, or as more than one rising edge, in any window exactly one period long. A waveform's phase does not change the count over such a window, so the bench can measure without aligning to the counter. A buffer that loads too early cuts short the pulse already under way, which is visible about twenty clocks after the write. Faults in the inversion stages or the drive-enable register appear on the pins one clock after the corresponding register changes.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  typedef enum logic {
    MODE_EDGE   = 1'b0,
    MODE_CENTER = 1'b1
  } cnt_mode_e;

  localparam int ADDR_POL       = 0;
  localparam int ADDR_PINV      = 1;
  localparam int ADDR_DRV       = 2;
  localparam int ADDR_MODE      = 3;
  localparam int ADDR_PRESC     = 4;
  localparam int ADDR_PER_BASE  = 8;
  localparam int ADDR_DUTY_BASE = 12;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] pol_o,
  output logic [NUM_CH-1:0] pinv_o,
  output logic [NUM_CH-1:0] drv_o,
  output logic [NUM_CH-1:0] mode_o,
  output logic [NUM_CH-1:0] presc_o,
  output logic [CNT_W-1:0]  per_o  [NUM_CH],
  output logic [CNT_W-1:0]  duty_o [NUM_CH]
);

  logic [NUM_CH-1:0] pol_n, pinv_n, drv_n, mode_n, presc_n;
  logic [CNT_W-1:0]  per_n  [NUM_CH];
  logic [CNT_W-1:0]  duty_n [NUM_CH];

  always_comb begin
    pol_n   = pol_o;
    pinv_n  = pinv_o;
    drv_n   = drv_o;
    mode_n  = mode_o;
    presc_n = presc_o;
    if (wr_en) begin
      if (wr_addr == ADDR_W'(ADDR_POL))   pol_n   = wr_data[NUM_CH-1:0];
      if (wr_addr == ADDR_W'(ADDR_PINV))  pinv_n  = wr_data[NUM_CH-1:0];
      if (wr_addr == ADDR_W'(ADDR_DRV))   drv_n   = wr_data[NUM_CH-1:0];
      if (wr_addr == ADDR_W'(ADDR_MODE))  mode_n  = wr_data[NUM_CH-1:0];
      if (wr_addr == ADDR_W'(ADDR_PRESC)) presc_n = wr_data[NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_o   <= '0;
      pinv_o  <= '0;
      drv_o   <= '0;
      mode_o  <= '0;
      presc_o <= '0;
    end else begin
      pol_o   <= pol_n;
      pinv_o  <= pinv_n;
      drv_o   <= drv_n;
      mode_o  <= mode_n;
      presc_o <= presc_n;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chreg
    logic per_we, duty_we;
    assign per_we  = wr_en && (wr_addr == ADDR_W'(ADDR_PER_BASE + i));
    assign duty_we = wr_en && (wr_addr == ADDR_W'(ADDR_DUTY_BASE + i));

    always_comb begin
      per_n[i]  = per_we  ? wr_data[CNT_W-1:0] : per_o[i];
      duty_n[i] = duty_we ? wr_data[CNT_W-1:0] : duty_o[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        per_o[i]  <= '0;
        duty_o[i] <= '0;
      end else begin
        per_o[i]  <= per_n[i];
        duty_o[i] <= duty_n[i];
      end
    end
  end

  // R7
  pol_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(ADDR_POL)) |=> (pol_o == $past(wr_data[NUM_CH-1:0])));

  // R11
  ign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(5)) |=> ($stable(drv_o) && $stable(pol_o) && $stable(mode_o)));

endmodule

// File: rtl/pwm_tickgen.sv
module pwm_tickgen #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_slow,
  output logic tick
);

  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] pcnt_q, pcnt_n;

  always_comb begin
    pcnt_n = (pcnt_q == LAST) ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_n;
  end

  assign tick = !sel_slow || (pcnt_q == LAST);

  // R4
  slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_slow && $past(sel_slow) && tick) |-> !$past(tick));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_quad_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_mode_e        mode_cfg,
  input  logic [CNT_W-1:0] per_cfg,
  input  logic [CNT_W-1:0] duty_cfg,
  output logic             raw
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] per_act_q, per_act_n;
  logic [CNT_W-1:0] duty_act_q, duty_act_n;
  cnt_mode_e        mode_act_q, mode_act_n;
  logic             down_q, down_n;
  logic             load;

  always_comb begin
    cnt_n      = cnt_q;
    down_n     = down_q;
    per_act_n  = per_act_q;
    duty_act_n = duty_act_q;
    mode_act_n = mode_act_q;
    load       = 1'b0;
    if (tick) begin
      if (mode_act_q == MODE_EDGE) begin
        if (cnt_q >= per_act_q) load  = 1'b1;
        else                    cnt_n = cnt_q + 1'b1;
      end else if (!down_q) begin
        if (cnt_q >= per_act_q) down_n = 1'b1;
        else                    cnt_n  = cnt_q + 1'b1;
      end else begin
        if (cnt_q == '0) load  = 1'b1;
        else             cnt_n = cnt_q - 1'b1;
      end
    end
    if (load) begin
      cnt_n      = '0;
      down_n     = 1'b0;
      per_act_n  = per_cfg;
      duty_act_n = duty_cfg;
      mode_act_n = mode_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      down_q     <= 1'b0;
      per_act_q  <= '0;
      duty_act_q <= '0;
      mode_act_q <= MODE_EDGE;
    end else begin
      cnt_q      <= cnt_n;
      down_q     <= down_n;
      per_act_q  <= per_act_n;
      duty_act_q <= duty_act_n;
      mode_act_q <= mode_act_n;
    end
  end

  assign raw = (cnt_q < duty_act_q);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_act_q);

  // R4
  cnt_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> $past(tick));

  // R6
  act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(per_act_q) || !$stable(duty_act_q) || !$stable(mode_act_q)) |-> $past(load));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (down_q && $past(down_q) && !$stable(cnt_q)) |-> (CNT_W'(cnt_q + 1'b1) == $past(cnt_q)));

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] raw,
  input  logic [NUM_CH-1:0] pol,
  input  logic [NUM_CH-1:0] pinv,
  input  logic [NUM_CH-1:0] drv,
  output logic [NUM_CH-1:0] pin,
  output logic [NUM_CH-1:0] oe
);

  logic [NUM_CH-1:0] stage1, pin_n;

  always_comb begin
    stage1 = raw ^ pol;
    pin_n  = stage1 ^ pinv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= '0;
      oe  <= '0;
    end else begin
      pin <= pin_n;
      oe  <= drv;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R8
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pol[i]) && $past(pinv[i])) |-> (pin[i] == $past(raw[i])));
    // R9
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv[i]) |=> oe[i]);
  end

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CNT_W     = 16,
  parameter int PRESC_DIV = 64,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] pwm_pin,
  output logic [NUM_CH-1:0] pwm_oe
);

  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic [NUM_CH-1:0] pol, pinv, drv, mode, presc, raw, tick;
  logic [CNT_W-1:0]  per  [NUM_CH];
  logic [CNT_W-1:0]  duty [NUM_CH];

  pwm_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(srst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pol_o(pol), .pinv_o(pinv), .drv_o(drv), .mode_o(mode), .presc_o(presc),
    .per_o(per), .duty_o(duty)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_tickgen #(.DIV(PRESC_DIV)) u_tick (
      .clk(clk), .rst_n(srst_n), .sel_slow(presc[i]), .tick(tick[i])
    );

    pwm_channel #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(srst_n), .tick(tick[i]),
      .mode_cfg(cnt_mode_e'(mode[i])),
      .per_cfg(per[i]), .duty_cfg(duty[i]),
      .raw(raw[i])
    );
  end

  pwm_outstage #(.NUM_CH(NUM_CH)) u_out (
    .clk(clk), .rst_n(srst_n),
    .raw(raw), .pol(pol), .pinv(pinv), .drv(drv),
    .pin(pwm_pin), .oe(pwm_oe)
  );

endmodule

// File: tb/pwm_quad_test.sv
module pwm_quad_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm_pin;
  logic [3:0]  pwm_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_quad uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_pin(pwm_pin), .pwm_oe(pwm_oe)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic        mode;
    logic        presc;
    logic [15:0] per;
    logic [15:0] duty;
    logic        pol;
    logic        pinv;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 16'd9,   16'd3,   1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 16'd255, 16'd128, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b0, 16'd9,   16'd4,   1'b0, 1'b0},
    '{2'd3, 1'b0, 1'b1, 16'd3,   16'd1,   1'b0, 1'b0},
    '{2'd0, 1'b1, 1'b1, 16'd3,   16'd2,   1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 16'd15,  16'd0,   1'b0, 1'b0},
    '{2'd2, 1'b0, 1'b0, 16'd15,  16'd20,  1'b0, 1'b0},
    '{2'd3, 1'b0, 1'b0, 16'd9,   16'd3,   1'b1, 1'b0},
    '{2'd0, 1'b0, 1'b0, 16'd9,   16'd3,   1'b0, 1'b1},
    '{2'd1, 1'b1, 1'b0, 16'd7,   16'd3,   1'b1, 1'b1}
  };

  logic [3:0] pol_w = '0, pinv_w = '0, mode_w = '0, presc_w = '0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 4'(addr);
    wr_data = 16'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic measure(input int ch, input int len, output int hi, output int rises);
    logic prev, cur;
    hi = 0;
    rises = 0;
    prev = pwm_pin[ch];
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      cur = pwm_pin[ch];
      if (cur) hi++;
      if (cur && !prev) rises++;
      prev = cur;
    end
  endtask

  function automatic void expect_of(input vec_t v, output int len, output int hi);
    int div, n, d;
    div = v.presc ? 64 : 1;
    n = int'(v.per) + 1;
    d = (int'(v.duty) > int'(v.per)) ? n : int'(v.duty);
    if (v.mode) begin len = 2 * n * div; hi = 2 * d * div; end
    else        begin len = n * div;     hi = d * div;     end
    if (v.pol ^ v.pinv) hi = len - hi;
  endfunction

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int len, hi, rises, exp_r;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 pin at reset", int'(pwm_pin), 0);
    check("R10 oe at reset", int'(pwm_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 pin after release", int'(pwm_pin), 0);

    // R2 R3 R4 R5 R7 R8: vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      pol_w[v.ch]   = v.pol;
      pinv_w[v.ch]  = v.pinv;
      mode_w[v.ch]  = v.mode;
      presc_w[v.ch] = v.presc;
      wr(8 + int'(v.ch), int'(v.per));
      wr(12 + int'(v.ch), int'(v.duty));
      wr(3, int'(mode_w));
      wr(4, int'(presc_w));
      wr(0, int'(pol_w));
      wr(1, int'(pinv_w));
      expect_of(v, len, hi);
      repeat (600 + 2 * len) @(negedge clk);
      measure(int'(v.ch), len, hi, rises);
      expect_of(v, len, exp_r);
      check($sformatf("R2/R3/R4/R5/R7/R8 vec %0d active cycles", i), hi, exp_r);
      exp_r = (exp_r > 0 && exp_r < len) ? 1 : 0;
      check($sformatf("R2/R3 vec %0d rising edges per period", i), rises, exp_r);
    end

    // R1: channel 2 (full width) unaffected by later writes to other channels
    measure(2, 16, hi, rises);
    check("R1 ch2 still constant active", hi, 16);

    // R9: drive enables
    wr(2, 4'b1010);
    @(negedge clk);
    check("R9 oe after write", int'(pwm_oe), 4'b1010);

    // R11: writes to unused addresses are ignored
    wr(5, 16'hFFFF);
    wr(6, 16'hFFFF);
    wr(7, 16'hFFFF);
    repeat (2) @(negedge clk);
    check("R11 oe unchanged by unused address", int'(pwm_oe), 4'b1010);
    measure(2, 16, hi, rises);
    check("R11 ch2 unchanged by unused address", hi, 16);

    // R6: width change mid-period only applies from next period
    pol_w[0] = 1'b0; pinv_w[0] = 1'b0; mode_w[0] = 1'b0; presc_w[0] = 1'b0;
    wr(0, int'(pol_w));
    wr(1, int'(pinv_w));
    wr(3, int'(mode_w));
    wr(4, int'(presc_w));
    wr(8, 99);
    wr(12, 50);
    repeat (400) @(negedge clk);
    begin : find_rise
      logic prev;
      prev = pwm_pin[0];
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (pwm_pin[0] && !prev) disable find_rise;
        prev = pwm_pin[0];
      end
    end
    wr(12, 10);
    repeat (18) @(negedge clk);
    check("R6 old width kept in current period", int'(pwm_pin[0]), 1);
    repeat (200) @(negedge clk);
    measure(0, 100, hi, rises);
    check("R6 new width in later period", hi, 10);

    // R8: both inversion bits set on channel 0 gives raw sense
    pol_w[0] = 1'b1; pinv_w[0] = 1'b1;
    wr(0, int'(pol_w));
    wr(1, int'(pinv_w));
    repeat (5) @(negedge clk);
    measure(0, 100, hi, rises);
    check("R8 double inversion cancels", hi, 10);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule